// File: doc/BRIEF.md
# Template Block Matcher (Minimum Absolute-Difference Search)

The block locates the position at which a small square template best fits inside a larger square search window. For each candidate placement it adds up the absolute difference between every template pixel and the window pixel under it. It then reports the placement whose total is lowest. Before a search, the template and the window are loaded into two internal memories through plain write ports, one pixel per clock.

A one-cycle start pulse launches an exhaustive scan, which processes one pixel difference per clock. When the scan ends, a one-cycle done pulse appears. At that point the best column offset, the best row offset and the minimum sum are valid, and they stay unchanged until the next accepted start.

A coarse mode, selected at start, samples only every second pixel in each axis and steps the offsets by two. This cuts the work to roughly one fifteenth of the full-resolution scan and gives an approximate position that a later stage can refine.

Top module: `sad_block_matcher`

## Requirements
- R1: For one placement, the sum is the total over the compared template pixels of |template(r,c) − window(row offset + r, column offset + c)|. With all template pixels at 255 and all window pixels at 0, best_sad equals 255 × TPL × TPL, with no overflow.
- R2: In fine mode, every column offset and every row offset from 0 to WIN − TPL is evaluated, which gives (WIN − TPL + 1)² placements.
- R3: best_sad reports the smallest sum over all evaluated placements, and best_col / best_row report the offsets of that placement.
- R4: When several placements share the minimum, the first one in raster order is reported. Raster order takes rows of offsets top to bottom and, within a row, columns left to right.
- R5: When coarse is high at start, only template pixels with even row and even column indices are compared, and offsets take only even values from 0 to WIN − TPL. Offsets are reported in full-resolution pixel units. Template pixels at odd indices have no effect on the result.
- R6: done is a single-cycle pulse. It is high in the cycle after the (N+1)-th rising clock edge that follows the edge sampling start, where N = placements × compared pixels per placement.
- R7: busy rises on the edge that accepts start and falls on the edge that raises done. A start seen while busy is high is ignored: the scan is not restarted and its timing and result are unchanged.
- R8: best_col, best_row and best_sad do not change while busy is low.
- R9: While rst_n is low at a clock edge, busy, done and all result outputs become 0.
- R10: A pixel written with tpl_we or win_we is stored at address row × width + column, where width is TPL for the template and WIN for the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tpl_we | input | 1 | Template pixel write enable |
| tpl_waddr | input | log2(TPL²) | Template write address, row × TPL + column |
| tpl_wdata | input | PIX_W | Template pixel value |
| win_we | input | 1 | Window pixel write enable |
| win_waddr | input | log2(WIN²) | Window write address, row × WIN + column |
| win_wdata | input | PIX_W | Window pixel value |
| start | input | 1 | One-cycle request to begin a scan |
| coarse | input | 1 | Selects the half-resolution scan, sampled with start |
| busy | output | 1 | High while a scan is running |
| done | output | 1 | One-cycle pulse when the result is ready |
| best_col | output | log2(WIN−TPL+1) rounded up | Column offset of the best placement |
| best_row | output | log2(WIN−TPL+1) rounded up | Row offset of the best placement |
| best_sad | output | PIX_W + log2(TPL²) | Minimum absolute-difference sum |

## Verification
The bench sweeps a reduced 4×4 template over an 8×8 window in both modes and compares each result with a sum computed in the bench. The sharpest case is ties. A window made of repeating 2×2 tiles gives several zero-sum placements, and a design that used <= in the minimum comparison would report the last of them instead of the first. A saturated template over a black window checks that the full-size sum is carried without wrapping. In coarse mode, odd-index template pixels are changed between runs: a design that sampled the wrong phase, or stepped the offsets by one, would change its answer or its done timing. A start pulse injected mid-scan would shift the done cycle in a design that restarts on it. Checking the outputs after done shows whether a design lets the results drift while idle.

// File: rtl/sad_pkg.sv
// Shared types for the block matcher.
// Assumes: nothing beyond standard SystemVerilog.
package sad_pkg;

    // Per-pixel control tag that travels with a memory read.
    typedef struct packed {
        logic valid;   // a pixel difference is being issued
        logic first;   // first pixel of a placement
        logic last;    // last pixel of a placement
        logic fin;     // last pixel of the whole scan
    } pix_tag_t;

endpackage

// File: rtl/sad_pixel_mem.sv
// Pixel store with one write port and one registered read port.
// Assumes: read data is valid one cycle after the address is presented.
module sad_pixel_mem #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);

    logic [PIX_W-1:0] store [DEPTH];

    // Write a pixel when enabled.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Registered read, one cycle of latency.
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end

endmodule

// File: rtl/sad_scan_ctrl.sv
// Walks every placement and, inside each, every compared template pixel.
// Emits both read addresses, the placement offsets and a control tag.
// Assumes: TPL and WIN are powers of two; WIN-TPL is even when coarse is used.
module sad_scan_ctrl
    import sad_pkg::*;
#(
    parameter int TPL   = 32,
    parameter int WIN   = 64,
    localparam int MAXO = WIN - TPL,
    localparam int OW   = $clog2(MAXO + 1),
    localparam int TW   = $clog2(TPL),
    localparam int WW   = $clog2(WIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            coarse,
    output logic [2*TW-1:0] tpl_raddr,
    output logic [2*WW-1:0] win_raddr,
    output logic [OW-1:0]   off_col,
    output logic [OW-1:0]   off_row,
    output pix_tag_t        tag
);

    logic          running;
    logic          coarse_q;
    logic [TW-1:0] tx, ty;
    logic [OW-1:0] ox, oy;
    logic [1:0]    step;
    logic          tx_end, ty_end, ox_end, oy_end;
    logic [WW-1:0] wrow, wcol;

    // Step size and end-of-range flags for each counter.
    always_comb begin
        step   = coarse_q ? 2'd2 : 2'd1;
        tx_end = coarse_q ? (tx == TW'(TPL - 2)) : (tx == TW'(TPL - 1));
        ty_end = coarse_q ? (ty == TW'(TPL - 2)) : (ty == TW'(TPL - 1));
        ox_end = (ox == OW'(MAXO));
        oy_end = (oy == OW'(MAXO));
    end

    // Nested counters: template column, template row, offset column, offset row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            coarse_q <= 1'b0;
            tx <= '0; ty <= '0; ox <= '0; oy <= '0;
        end else if (go) begin
            running  <= 1'b1;
            coarse_q <= coarse;
            tx <= '0; ty <= '0; ox <= '0; oy <= '0;
        end else if (running) begin
            if (!tx_end) begin
                tx <= tx + TW'(step);
            end else begin
                tx <= '0;
                if (!ty_end) begin
                    ty <= ty + TW'(step);
                end else begin
                    ty <= '0;
                    if (!ox_end) begin
                        ox <= ox + OW'(step);
                    end else begin
                        ox <= '0;
                        if (!oy_end) oy <= oy + OW'(step);
                        else         running <= 1'b0;
                    end
                end
            end
        end
    end

    // Address formation and tag for the pixel issued this cycle.
    always_comb begin
        wrow      = WW'(oy) + WW'(ty);
        wcol      = WW'(ox) + WW'(tx);
        tpl_raddr = {ty, tx};
        win_raddr = {wrow, wcol};
        off_col   = ox;
        off_row   = oy;
        tag.valid = running;
        tag.first = running && (tx == '0) && (ty == '0);
        tag.last  = running && tx_end && ty_end;
        tag.fin   = running && tx_end && ty_end && ox_end && oy_end;
    end

    // Offsets stay within the window and are even in coarse mode.
    assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (ox <= OW'(MAXO)) && (oy <= OW'(MAXO)));
    assert_coarse_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && coarse_q) |-> (ox[0] == 1'b0) && (oy[0] == 1'b0)
                                  && (tx[0] == 1'b0) && (ty[0] == 1'b0));
    // Offsets do not move in the middle of a placement.
    assert_offset_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tx_end) |=> (ox == $past(ox)) && (oy == $past(oy)));

endmodule

// File: rtl/sad_accum_min.sv
// Accumulates absolute pixel differences per placement and keeps the running
// minimum with its offsets. Strict less-than keeps the first minimum in scan order.
// Assumes: tag and offsets arrive aligned with the two pixel values.
module sad_accum_min
    import sad_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TPL   = 32,
    parameter int OW    = 6,
    localparam int ACC_W = PIX_W + $clog2(TPL * TPL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  pix_tag_t         tag,
    input  logic [OW-1:0]    off_col,
    input  logic [OW-1:0]    off_row,
    input  logic [PIX_W-1:0] tpl_pix,
    input  logic [PIX_W-1:0] win_pix,
    output logic [OW-1:0]    best_col,
    output logic [OW-1:0]    best_row,
    output logic [ACC_W-1:0] best_sad,
    output logic             done
);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] diff;
    logic [ACC_W-1:0] sum_now;
    logic             have;

    // Absolute difference and the placement sum including this pixel.
    always_comb begin
        diff    = (tpl_pix > win_pix) ? ACC_W'(tpl_pix - win_pix)
                                      : ACC_W'(win_pix - tpl_pix);
        sum_now = tag.first ? diff : acc + diff;
    end

    // Running sum for the current placement.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (tag.valid) acc <= sum_now;
    end

    // Minimum tracking and the end-of-scan pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have     <= 1'b0;
            best_col <= '0;
            best_row <= '0;
            best_sad <= '0;
            done     <= 1'b0;
        end else begin
            done <= tag.valid && tag.fin;
            if (clr) begin
                have <= 1'b0;
            end else if (tag.valid && tag.last && (!have || sum_now < best_sad)) begin
                have     <= 1'b1;
                best_col <= off_col;
                best_row <= off_row;
                best_sad <= sum_now;
            end
        end
    end

    // The recorded minimum never grows within a scan.
    assert_min_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (have && $past(have) && !$past(clr)) |-> best_sad <= $past(best_sad));
    // The end-of-scan pulse lasts one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sad_block_matcher.sv
// Top of the block matcher: two pixel stores, the scan controller, a one-cycle
// tag delay matching the store read latency, and the accumulate/minimum stage.
// Assumes: memories are not written while busy is high.
module sad_block_matcher
    import sad_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TPL   = 32,
    parameter int WIN   = 64,
    localparam int TAW  = $clog2(TPL * TPL),
    localparam int WAW  = $clog2(WIN * WIN),
    localparam int OW   = $clog2(WIN - TPL + 1),
    localparam int ACC_W = PIX_W + $clog2(TPL * TPL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tpl_we,
    input  logic [TAW-1:0]   tpl_waddr,
    input  logic [PIX_W-1:0] tpl_wdata,
    input  logic             win_we,
    input  logic [WAW-1:0]   win_waddr,
    input  logic [PIX_W-1:0] win_wdata,
    input  logic             start,
    input  logic             coarse,
    output logic             busy,
    output logic             done,
    output logic [OW-1:0]    best_col,
    output logic [OW-1:0]    best_row,
    output logic [ACC_W-1:0] best_sad
);

    logic             go;
    logic             busy_q;
    logic [TAW-1:0]   tpl_raddr;
    logic [WAW-1:0]   win_raddr;
    logic [PIX_W-1:0] tpl_pix, win_pix;
    logic [OW-1:0]    oc, orow, oc_d, orow_d;
    pix_tag_t         tag, tag_d;
    logic             done_w;

    // Accept start only when idle.
    always_comb go = start && !busy_q;

    // Busy from accepted start until the result edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (go)     busy_q <= 1'b1;
        else if (done_w) busy_q <= 1'b0;
    end

    sad_pixel_mem #(.PIX_W(PIX_W), .DEPTH(TPL * TPL)) u_tpl_mem (
        .clk(clk), .we(tpl_we), .waddr(tpl_waddr), .wdata(tpl_wdata),
        .raddr(tpl_raddr), .rdata(tpl_pix)
    );

    sad_pixel_mem #(.PIX_W(PIX_W), .DEPTH(WIN * WIN)) u_win_mem (
        .clk(clk), .we(win_we), .waddr(win_waddr), .wdata(win_wdata),
        .raddr(win_raddr), .rdata(win_pix)
    );

    sad_scan_ctrl #(.TPL(TPL), .WIN(WIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .coarse(coarse),
        .tpl_raddr(tpl_raddr), .win_raddr(win_raddr),
        .off_col(oc), .off_row(orow), .tag(tag)
    );

    // Delay tag and offsets by the store read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_d  <= '0;
            oc_d   <= '0;
            orow_d <= '0;
        end else begin
            tag_d  <= tag;
            oc_d   <= oc;
            orow_d <= orow;
        end
    end

    // The result edge is the one where the final placement is compared.
    always_comb done_w = tag_d.valid && tag_d.fin;

    sad_accum_min #(.PIX_W(PIX_W), .TPL(TPL), .OW(OW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(go), .tag(tag_d),
        .off_col(oc_d), .off_row(orow_d),
        .tpl_pix(tpl_pix), .win_pix(win_pix),
        .best_col(best_col), .best_row(best_row), .best_sad(best_sad),
        .done(done)
    );

    always_comb busy = busy_q;

    // done rises together with busy falling.
    assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    // A start while busy does not drop or restart the scan.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done_w) |=> busy);
    // Results hold while idle.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(best_sad) && $stable(best_col)
                                     && $stable(best_row)));

endmodule

// File: tb/tb_sad_block_matcher.sv
// Self-checking bench on a reduced 4x4 template / 8x8 window configuration.
module tb_sad_block_matcher;

    localparam int PIX_W = 8;
    localparam int TPL   = 4;
    localparam int WIN   = 8;
    localparam int TAW   = $clog2(TPL * TPL);
    localparam int WAW   = $clog2(WIN * WIN);
    localparam int OW    = $clog2(WIN - TPL + 1);
    localparam int ACC_W = PIX_W + $clog2(TPL * TPL);
    localparam int MAXO  = WIN - TPL;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tpl_we = 1'b0;
    logic [TAW-1:0]   tpl_waddr = '0;
    logic [PIX_W-1:0] tpl_wdata = '0;
    logic             win_we = 1'b0;
    logic [WAW-1:0]   win_waddr = '0;
    logic [PIX_W-1:0] win_wdata = '0;
    logic             start = 1'b0;
    logic             coarse = 1'b0;
    logic             busy, done;
    logic [OW-1:0]    best_col, best_row;
    logic [ACC_W-1:0] best_sad;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int tmodel [TPL*TPL];
    int wmodel [WIN*WIN];
    int ex_col, ex_row, ex_sad;
    int seed = 12345;

    sad_block_matcher #(.PIX_W(PIX_W), .TPL(TPL), .WIN(WIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .tpl_we(tpl_we), .tpl_waddr(tpl_waddr), .tpl_wdata(tpl_wdata),
        .win_we(win_we), .win_waddr(win_waddr), .win_wdata(win_wdata),
        .start(start), .coarse(coarse),
        .busy(busy), .done(done),
        .best_col(best_col), .best_row(best_row), .best_sad(best_sad)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lcg();
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        return (seed >> 16) & 255;
    endfunction

    // Push both model arrays into the stores (R10 addressing: row*width+col).
    task automatic load_all();
        for (int i = 0; i < TPL*TPL; i++) begin
            @(negedge clk);
            tpl_we = 1'b1; tpl_waddr = TAW'(i); tpl_wdata = PIX_W'(tmodel[i]);
        end
        for (int i = 0; i < WIN*WIN; i++) begin
            @(negedge clk);
            tpl_we = 1'b0;
            win_we = 1'b1; win_waddr = WAW'(i); win_wdata = PIX_W'(wmodel[i]);
        end
        @(negedge clk);
        tpl_we = 1'b0; win_we = 1'b0;
    endtask

    // Arithmetic reference: minimum sum, first in raster order on ties.
    task automatic model(input bit crs);
        int st;
        st = crs ? 2 : 1;
        ex_sad = -1;
        for (int oy = 0; oy <= MAXO; oy += st)
            for (int ox = 0; ox <= MAXO; ox += st) begin
                int s;
                s = 0;
                for (int r = 0; r < TPL; r += st)
                    for (int c = 0; c < TPL; c += st) begin
                        int d;
                        d = tmodel[r*TPL+c] - wmodel[(oy+r)*WIN + ox + c];
                        s += (d < 0) ? -d : d;
                    end
                if (ex_sad < 0 || s < ex_sad) begin
                    ex_sad = s; ex_col = ox; ex_row = oy;
                end
            end
    endtask

    // Run one scan and check timing, busy and result; optional mid-scan start.
    task automatic run(input bit crs, input bit poke, input string tagname);
        int n, j, st, np;
        st = crs ? 2 : 1;
        np = MAXO / st + 1;
        n  = np * np * (TPL / st) * (TPL / st);
        model(crs);
        @(negedge clk);
        start = 1'b1; coarse = crs;
        @(negedge clk);
        start = 1'b0; coarse = 1'b0;
        j = 0;
        chk({"R7 busy after start ", tagname}, int'(busy), 1);
        while (!done && j < 5000) begin
            @(negedge clk);
            j++;
            start = (poke && j == 10) ? 1'b1 : 1'b0;
            if (!done) begin
                if (!busy) begin
                    chk({"R7 busy held ", tagname}, int'(busy), 1);
                    break;
                end
            end
        end
        start = 1'b0;
        chk({"R6 done latency ", tagname}, j, n + 1);
        chk({"R7 busy low at done ", tagname}, int'(busy), 0);
        chk({"R3 best_col ", tagname}, int'(best_col), ex_col);
        chk({"R3 best_row ", tagname}, int'(best_row), ex_row);
        chk({"R1 best_sad ", tagname}, int'(best_sad), ex_sad);
        @(negedge clk);
        chk({"R6 done single cycle ", tagname}, int'(done), 0);
    endtask

    initial begin
        int c0, r0, s0;
        // R9: reset state.
        repeat (3) @(negedge clk);
        chk("R9 busy", int'(busy), 0);
        chk("R9 done", int'(done), 0);
        chk("R9 best_sad", int'(best_sad), 0);
        chk("R9 best_col", int'(best_col), 0);
        rst_n = 1'b1;

        // R1/R2/R3/R10: random window, template cut from (row 3, col 1).
        for (int i = 0; i < WIN*WIN; i++) wmodel[i] = lcg();
        for (int r = 0; r < TPL; r++)
            for (int c = 0; c < TPL; c++) tmodel[r*TPL+c] = wmodel[(3+r)*WIN + 1 + c];
        load_all();
        run(1'b0, 1'b0, "fine cut");
        chk("R2 far corner found", int'(best_col)*16 + int'(best_row), 1*16 + 3);

        // R2: template cut from the last placement (row 4, col 4).
        for (int r = 0; r < TPL; r++)
            for (int c = 0; c < TPL; c++) tmodel[r*TPL+c] = wmodel[(4+r)*WIN + 4 + c];
        load_all();
        run(1'b0, 1'b0, "fine last");

        // R7: start pulse mid-scan is ignored.
        run(1'b0, 1'b1, "poke");

        // R8: outputs hold while idle.
        c0 = int'(best_col); r0 = int'(best_row); s0 = int'(best_sad);
        repeat (20) @(negedge clk);
        chk("R8 hold col", int'(best_col), c0);
        chk("R8 hold row", int'(best_row), r0);
        chk("R8 hold sad", int'(best_sad), s0);

        // R4: tiled window, many zero-sum placements, first in raster order wins.
        for (int r = 0; r < WIN; r++)
            for (int c = 0; c < WIN; c++) wmodel[r*WIN+c] = ((r % 2) * 2 + (c % 2)) * 40 + 5;
        for (int r = 0; r < TPL; r++)
            for (int c = 0; c < TPL; c++) tmodel[r*TPL+c] = wmodel[(3+r)*WIN + 3 + c];
        load_all();
        run(1'b0, 1'b0, "tie");
        chk("R4 tie col", int'(best_col), 1);
        chk("R4 tie row", int'(best_row), 1);

        // R1: saturated sum without overflow.
        for (int i = 0; i < WIN*WIN; i++) wmodel[i] = 0;
        for (int i = 0; i < TPL*TPL; i++) tmodel[i] = 255;
        load_all();
        run(1'b0, 1'b0, "max");
        chk("R1 max sum", int'(best_sad), 255 * TPL * TPL);

        // R5: coarse scan on random data, template from (row 2, col 4).
        for (int i = 0; i < WIN*WIN; i++) wmodel[i] = lcg();
        for (int r = 0; r < TPL; r++)
            for (int c = 0; c < TPL; c++) tmodel[r*TPL+c] = wmodel[(2+r)*WIN + 4 + c];
        load_all();
        run(1'b1, 1'b0, "coarse");
        chk("R5 coarse col", int'(best_col), 4);
        chk("R5 coarse row", int'(best_row), 2);
        c0 = int'(best_col); r0 = int'(best_row); s0 = int'(best_sad);

        // R5: odd-index template pixels have no effect in coarse mode.
        for (int r = 0; r < TPL; r++)
            for (int c = 0; c < TPL; c++)
                if ((r % 2) == 1 || (c % 2) == 1) tmodel[r*TPL+c] = 255 - tmodel[r*TPL+c];
        load_all();
        run(1'b1, 1'b0, "coarse odd");
        chk("R5 odd ignored col", int'(best_col), c0);
        chk("R5 odd ignored row", int'(best_row), r0);
        chk("R5 odd ignored sad", int'(best_sad), s0);

        // Same data in fine mode, where those pixels now count.
        run(1'b0, 1'b0, "fine after coarse");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule